// File: doc/BRIEF.md
# Correlator Result Readout Sequencer

This block drains a bank of per-channel result registers through a 16-bit parallel output port. The port is paced by a strobe from the host. When the upstream integrator has results waiting, it raises a ready flag. The host then pulses a start request, which arms a position counter. After that, each strobe emits one item. An item is either the upper 16 bits of a channel entry (word mode) or one byte of those 16 bits (byte mode). Channels are emitted from the highest index downward.

The sequencer drives a channel index into the holding bank. The bank answers combinationally with the upper 16 bits of the addressed entry. When the counter has run out, the sequencer pulses a clear output so that the shared ready flag drops and the read cycle closes. On each clock, exactly one operation takes effect. From highest to lowest priority they are: reset, start, end, dump, idle.

Top module: `corr_readout_seq`

## Requirements
- R1: A synchronous active-high reset clears the output data to 0, keeps the clear output low, and ends any read cycle. It overrides start requests and strobes in the same cycle.
- R2: With results ready high, a start request arms a read cycle. The counter is loaded with 32 when word mode is selected (byte_mode_i = 0) and with 64 when byte mode is selected (byte_mode_i = 1). A start in the same cycle as a strobe emits nothing.
- R3: In word mode, each strobe while ready is high decrements the counter to c. It then loads data_o with the full 16-bit bank value of channel c, so the order is 31, 30, and so on down to 0.
- R4: In byte mode, each strobe decrements the counter to c and emits a byte of channel c>>1. When c is odd, the byte is bits 15:8 of the bank value, so the high byte goes first. When c is even, the byte is bits 7:0. In both cases the byte is zero-extended into data_o bits 7:0, with bits 15:8 equal to 0.
- R5: A strobe has no effect, and data_o holds its value, when results ready is low or when no read cycle is armed.
- R6: In the first cycle after the counter reaches 0 with ready still high, ready_clear_o goes high for exactly one cycle and the read cycle ends. A strobe in that cycle, or any later strobe, leaves data_o unchanged.
- R7: While a read cycle is armed and the counter c is non-zero, chan_sel_o shows the channel of the next item: c-1 in word mode and (c-1)>>1 in byte mode.
- R8: A start request during an armed cycle reloads the counter and restarts emission from the top channel.
- R9: Dropping results ready in the middle of a cycle pauses it. Strobes are ignored while ready is low, and the counter is kept, so emission resumes at the next item once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| results_ready_i | input | 1 | Results-waiting flag from the integrator |
| start_req_i | input | 1 | Host request to begin a read cycle |
| strobe_i | input | 1 | Output strobe, one item per high cycle |
| byte_mode_i | input | 1 | 1 selects byte items, 0 selects word items |
| entry_hi_i | input | 16 | Upper 16 bits of the addressed bank entry |
| chan_sel_o | output | 5 | Channel index into the holding bank |
| data_o | output | 16 | Registered output item |
| ready_clear_o | output | 1 | One-cycle pulse that ends the read cycle |

## Verification
The bench drives a start request in the same cycle as a strobe. A design that lets the dump win would emit a stray item. It strobes in the cycle after the final item, where a design that lets the dump beat the end operation would wrap the counter and emit channel 31 again. Byte mode is run to completion with distinct byte patterns per channel, so a swapped lane order or missing zero-extension shows up as a wrong value. Ready is dropped mid-cycle and start is re-issued mid-cycle, exposing designs that lose the counter or skip the reload.

// File: rtl/corr_ro_pkg.sv
package corr_ro_pkg;

    localparam int DEF_CHANNELS = 32;
    localparam int DEF_OUT_W    = 16;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_RESET     = 3'd1,
        OP_START     = 3'd2,
        OP_END       = 3'd3,
        OP_DUMP_BYTE = 3'd4,
        OP_DUMP_WORD = 3'd5
    } ro_op_e;

    function automatic logic is_dump(input ro_op_e op);
        return (op == OP_DUMP_BYTE) || (op == OP_DUMP_WORD);
    endfunction

endpackage

// File: rtl/ro_op_decode.sv
module ro_op_decode
    import corr_ro_pkg::*;
(
    input  logic   rst,
    input  logic   ready,
    input  logic   start_req,
    input  logic   strobe,
    input  logic   byte_mode,
    input  logic   armed,
    input  logic   cnt_zero,
    output ro_op_e op
);

    always_comb begin
        if (rst) begin
            op = OP_RESET;
        end else if (ready && start_req) begin
            op = OP_START;
        end else if (ready && armed && cnt_zero) begin
            op = OP_END;
        end else if (ready && armed && strobe) begin
            op = byte_mode ? OP_DUMP_BYTE : OP_DUMP_WORD;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/ro_pos_counter.sv
module ro_pos_counter
    import corr_ro_pkg::*;
#(
    parameter  int CHANNELS = DEF_CHANNELS,
    localparam int CNT_W    = $clog2(2 * CHANNELS) + 1,
    localparam int IDX_W    = $clog2(CHANNELS) + 1
) (
    input  logic             clk,
    input  ro_op_e           op,
    input  logic             byte_mode,
    output logic             armed,
    output logic             cnt_zero,
    output logic [IDX_W-1:0] next_idx,
    output logic             clear_pulse
);

    localparam logic [CNT_W-1:0] LOAD_WORD = CNT_W'(CHANNELS);
    localparam logic [CNT_W-1:0] LOAD_BYTE = CNT_W'(2 * CHANNELS);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_dec;

    assign pos_dec  = pos_q - CNT_W'(1);
    assign cnt_zero = (pos_q == '0);
    assign next_idx = pos_dec[IDX_W-1:0];

    always_ff @(posedge clk) begin
        clear_pulse <= 1'b0;
        unique case (op)
            OP_RESET: begin
                pos_q <= '0;
                armed <= 1'b0;
            end
            OP_START: begin
                pos_q <= byte_mode ? LOAD_BYTE : LOAD_WORD;
                armed <= 1'b1;
            end
            OP_END: begin
                armed       <= 1'b0;
                clear_pulse <= 1'b1;
            end
            OP_DUMP_BYTE, OP_DUMP_WORD: begin
                pos_q <= pos_dec;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ro_out_stage.sv
module ro_out_stage
    import corr_ro_pkg::*;
#(
    parameter  int CHANNELS = DEF_CHANNELS,
    parameter  int OUT_W    = DEF_OUT_W,
    localparam int IDX_W    = $clog2(CHANNELS) + 1,
    localparam int ADDR_W   = $clog2(CHANNELS),
    localparam int BYTE_W   = OUT_W / 2
) (
    input  logic              clk,
    input  ro_op_e            op,
    input  logic              byte_mode,
    input  logic [IDX_W-1:0]  next_idx,
    input  logic [OUT_W-1:0]  entry_hi,
    output logic [ADDR_W-1:0] chan_sel,
    output logic [OUT_W-1:0]  data
);

    logic [BYTE_W-1:0] lane;

    assign chan_sel = byte_mode ? next_idx[IDX_W-1:1] : next_idx[ADDR_W-1:0];
    assign lane     = next_idx[0] ? entry_hi[OUT_W-1 -: BYTE_W]
                                  : entry_hi[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (op == OP_RESET) begin
            data <= '0;
        end else if (op == OP_DUMP_WORD) begin
            data <= entry_hi;
        end else if (is_dump(op)) begin
            data <= {{(OUT_W - BYTE_W){1'b0}}, lane};
        end
    end

endmodule

// File: rtl/corr_readout_seq.sv
module corr_readout_seq
    import corr_ro_pkg::*;
#(
    parameter  int CHANNELS = DEF_CHANNELS,
    parameter  int OUT_W    = DEF_OUT_W,
    localparam int ADDR_W   = $clog2(CHANNELS),
    localparam int IDX_W    = $clog2(CHANNELS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              results_ready_i,
    input  logic              start_req_i,
    input  logic              strobe_i,
    input  logic              byte_mode_i,
    input  logic [OUT_W-1:0]  entry_hi_i,
    output logic [ADDR_W-1:0] chan_sel_o,
    output logic [OUT_W-1:0]  data_o,
    output logic              ready_clear_o
);

    ro_op_e           op;
    logic             armed;
    logic             cnt_zero;
    logic [IDX_W-1:0] next_idx;

    ro_op_decode u_decode (
        .rst       (rst),
        .ready     (results_ready_i),
        .start_req (start_req_i),
        .strobe    (strobe_i),
        .byte_mode (byte_mode_i),
        .armed     (armed),
        .cnt_zero  (cnt_zero),
        .op        (op)
    );

    ro_pos_counter #(.CHANNELS(CHANNELS)) u_counter (
        .clk         (clk),
        .op          (op),
        .byte_mode   (byte_mode_i),
        .armed       (armed),
        .cnt_zero    (cnt_zero),
        .next_idx    (next_idx),
        .clear_pulse (ready_clear_o)
    );

    ro_out_stage #(.CHANNELS(CHANNELS), .OUT_W(OUT_W)) u_out (
        .clk       (clk),
        .op        (op),
        .byte_mode (byte_mode_i),
        .next_idx  (next_idx),
        .entry_hi  (entry_hi_i),
        .chan_sel  (chan_sel_o),
        .data      (data_o)
    );

endmodule

// File: rtl/ro_seq_checks.sv
module ro_seq_checks #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             results_ready_i,
    input logic             start_req_i,
    input logic             strobe_i,
    input logic             byte_mode_i,
    input logic [OUT_W-1:0] data_o,
    input logic             ready_clear_o
);

    // R1: reset leaves zero data and no clear pulse
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (data_o == '0) && !ready_clear_o);

    // R6: clear is a single-cycle pulse
    p_clear_single_r6: assert property (@(posedge clk) disable iff (rst)
        ready_clear_o |=> !ready_clear_o);

    // R6: clear only follows a cycle with ready high
    p_clear_needs_ready_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_clear_o) |-> $past(results_ready_i));

    // R5: with ready low nothing is emitted
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !results_ready_i |=> $stable(data_o));

    // R5: data changes only after a strobe
    p_strobe_needed_r5: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(data_o));

    // R4: a byte item leaves the upper half zero
    p_byte_zext_r4: assert property (@(posedge clk) disable iff (rst)
        (results_ready_i && strobe_i && byte_mode_i && !start_req_i)
        |=> ($stable(data_o) || (data_o[OUT_W-1:OUT_W/2] == '0)));

    // R2: a start cycle emits nothing
    p_start_no_emit_r2: assert property (@(posedge clk) disable iff (rst)
        (results_ready_i && start_req_i) |=> $stable(data_o));

endmodule

bind corr_readout_seq ro_seq_checks #(.OUT_W(OUT_W)) u_seq_checks (
    .clk             (clk),
    .rst             (rst),
    .results_ready_i (results_ready_i),
    .start_req_i     (start_req_i),
    .strobe_i        (strobe_i),
    .byte_mode_i     (byte_mode_i),
    .data_o          (data_o),
    .ready_clear_o   (ready_clear_o)
);

// File: tb/tb_corr_readout_seq.sv
`timescale 1ns/1ps
module tb_corr_readout_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        rdy;
    logic        start;
    logic        strobe;
    logic        bmode;
    logic [15:0] entry;
    logic [4:0]  chan;
    logic [15:0] data;
    logic        clr;

    logic [15:0] mem [32];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    int          m_cnt;
    bit          m_act;
    logic [15:0] m_data;
    bit          m_clr;

    always #2 clk = ~clk;

    assign entry = mem[chan];

    corr_readout_seq dut (
        .clk             (clk),
        .rst             (rst),
        .results_ready_i (rdy),
        .start_req_i     (start),
        .strobe_i        (strobe),
        .byte_mode_i     (bmode),
        .entry_hi_i      (entry),
        .chan_sel_o      (chan),
        .data_o          (data),
        .ready_clear_o   (clr)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input bit r, rd, bg, st, bm);
        int c;
        m_clr = 0;
        if (r) begin
            m_cnt = 0; m_act = 0; m_data = 16'h0;
        end else if (rd && bg) begin
            m_cnt = bm ? 64 : 32; m_act = 1;
        end else if (rd && m_act && m_cnt == 0) begin
            m_act = 0; m_clr = 1;
        end else if (rd && m_act && st) begin
            c = m_cnt - 1;
            m_cnt = c;
            if (bm)
                m_data = (c % 2 == 1) ? {8'h00, mem[c / 2][15:8]}
                                      : {8'h00, mem[c / 2][7:0]};
            else
                m_data = mem[c];
        end
    endtask

    task automatic step(input bit r, rd, bg, st, bm, input string tag);
        rst = r; rdy = rd; start = bg; strobe = st; bmode = bm;
        @(posedge clk);
        model_edge(r, rd, bg, st, bm);
        @(negedge clk);
        chk(data == m_data, tag, "data_o", data, m_data);
        chk(clr == m_clr, tag, "ready_clear_o", clr, m_clr);
        if (m_act && m_cnt != 0)
            chk(chan == (bm ? (m_cnt - 1) / 2 : m_cnt - 1), "R7", "chan_sel_o",
                chan, bm ? (m_cnt - 1) / 2 : m_cnt - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++)
            mem[i] = 16'((i * 16'h1357) ^ 16'hA5C3 ^ (i << 12));
        rst = 1; rdy = 0; start = 0; strobe = 0; bmode = 0;
        m_cnt = 0; m_act = 0; m_data = 0; m_clr = 0;

        // R1: reset overriding start and strobe
        step(1, 1, 1, 1, 0, "R1");
        step(1, 0, 0, 0, 0, "R1");
        // R5: strobes with ready low, and with ready high but no start
        step(0, 0, 0, 1, 0, "R5");
        step(0, 1, 0, 1, 0, "R5");
        step(0, 1, 0, 1, 1, "R5");
        // R2: start together with a strobe, word mode
        step(0, 1, 1, 1, 0, "R2");
        // R3: full word readout with gaps
        for (int k = 0; k < 32; k++) begin
            step(0, 1, 0, 1, 0, "R3");
            if (k % 5 == 0) step(0, 1, 0, 0, 0, "R3");
        end
        // R6: strobe after exhaustion ignored; clear pulses once
        step(0, 1, 0, 1, 0, "R6");
        step(0, 1, 0, 1, 0, "R6");
        step(0, 0, 0, 1, 0, "R6");
        // R2/R4: byte mode full readout
        step(0, 1, 1, 0, 1, "R2");
        for (int k = 0; k < 64; k++)
            step(0, 1, 0, 1, 1, "R4");
        step(0, 1, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 1, "R6");
        // R9: pause by dropping ready mid-cycle
        step(0, 1, 1, 0, 0, "R2");
        for (int k = 0; k < 6; k++) step(0, 1, 0, 1, 0, "R9");
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, "R9");
        for (int k = 0; k < 3; k++) step(0, 1, 0, 1, 0, "R9");
        // R8: restart mid-cycle in byte mode
        step(0, 1, 1, 1, 1, "R8");
        for (int k = 0; k < 5; k++) step(0, 1, 0, 1, 1, "R8");
        // R1: reset mid-cycle, then strobes are ignored
        step(1, 1, 0, 1, 1, "R1");
        step(0, 1, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 0, "R1");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule